// File: doc/BRIEF.md
# Fixed-Message Slot Controller

This block divides a row-addressed voice memory into between one and eight slots of near-equal size and lets each slot be recorded or played on its own. A 3-bit configuration code sets how many slots exist. One mode input chooses recording or playback for every slot. Eight active-low select lines start an operation on their own slot, so any slot can be reached in any order.

The controller works out each slot's first and last row from a built-in partition rule. While an operation runs it steps through the rows of the chosen slot, advancing one row per `row_tick` strobe from the sampling timebase. It drives the record and play enables and the row address, marks the end of a message when recording stops, and drives an active-low indicator. The memory returns the stored end-of-message flag of the addressed row on `row_eom`, and the block reads it combinationally during playback.

When the block is idle it copies the configuration code and the mode on every clock. While an operation runs it holds both, so changing them mid-operation has no effect until the block is idle again.

Top module: `fms_slot_ctrl`

## Requirements
- R1: The slot count is the configuration code read as binary plus one (code 0 gives 1 slot, code 7 gives 8). Select line `sel_n[i]` belongs to slot i. A select line whose slot number is not below the count starts nothing.
- R2: The array is split evenly across the slots. When the rows do not divide exactly, the lowest-numbered slots get one extra row each. A slot's first row is the sum of the row counts of all lower slots. For 256 rows this gives 86/85/85 for three slots, 52/51/51/51/51 for five slots, and 37/37/37/37/36/36/36 for seven slots.
- R3: A 512-row array follows the same rule in every case except three slots. There the split is 172/170/170. Six slots give 86/86/85/85/85/85, and eight slots give 64 each.
- R4: When several enabled select lines fall in the same cycle, the lowest-numbered enabled slot is the one started.
- R5: With the mode low, a falling select line in idle starts recording. From the next clock, `rec_en` is 1, `led_n` is 0 and `row_addr` is the slot's first row. Each `row_tick` then advances the row by one.
- R6: Recording stops when the held select line returns high. In that cycle `eom_set` is 1 and `row_addr` is the row being written. After the next clock `rec_en` is 0 and `led_n` is 1.
- R7: Recording also stops when `row_tick` arrives on the slot's last row. `eom_set` is 1 on that row, so exactly the slot's row count is recorded.
- R8: With the mode high, a falling select line starts playback at the slot's first row. A `row_tick` on a row whose `row_eom` is 1 ends it. `led_n` is then 0 for exactly LED_CYC cycles before the block returns to idle.
- R9: If playback reaches the slot's last row without finding an end flag, it stops after that row and `led_n` stays 1.
- R10: During playback, a falling edge on a select line other than the playing slot's is ignored. A second falling edge on the playing slot's own line stops playback, and `led_n` stays 1.
- R11: The configuration code and the mode are captured only while idle. Changing them during an operation changes neither the slot's boundaries nor the kind of operation.
- R12: After reset, `rec_en`, `play_en` and `eom_set` are 0, `led_n` is 1 and `row_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_code | input | 3 | Slot-count code, count = code + 1 |
| play_mode | input | 1 | 0 = record, 1 = playback, for all slots |
| sel_n | input | 8 | Active-low slot select lines, bit i = slot i |
| row_tick | input | 1 | One-cycle strobe: move to the next row |
| row_eom | input | 1 | End flag stored at the addressed row |
| row_addr | output | $clog2(ROWS) | Row being recorded or played |
| rec_en | output | 1 | Recording in progress |
| play_en | output | 1 | Playback in progress |
| eom_set | output | 1 | Write the end flag at `row_addr` this cycle |
| led_n | output | 1 | Active-low indicator |

## Verification
Several properties are checked on every clock. The partition always covers the whole array. The chosen slot is enabled and no lower requester exists. The row address stays inside the active slot and only moves forward by one. The captured configuration and mode stay still during an operation. Every end-flag write is followed by the end of recording. Only the bench's scenarios can show the exact row counts for every code on both array sizes, the LED pulse length, and that edges on other lines and mid-operation configuration changes leave the running operation alone.

// File: rtl/fms_pkg.sv
package fms_pkg;
  localparam int MAX_SLOTS = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_REC, ST_PLAY, ST_LED} fms_state_e;

  // Rows given to slot i when the array of 'total' rows is split n ways.
  function automatic int slot_rows(int total, int n, int i);
    int base;
    int spare;
    if (i >= n) return 0;
    if (total == 512 && n == 3) return (i == 0) ? 172 : 170;
    base  = total / n;
    spare = total % n;
    return base + ((i < spare) ? 1 : 0);
  endfunction
endpackage

// File: rtl/fms_partition.sv
module fms_partition #(
  parameter int ROWS = 256,
  localparam int RW  = $clog2(ROWS),
  localparam int NS  = fms_pkg::MAX_SLOTS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             code,
  output logic [NS-1:0][RW-1:0]  start_row,
  output logic [NS-1:0][RW-1:0]  last_row
);
  logic [NS-1:0][NS-1:0][RW:0] len_tbl;
  logic [NS-1:0][RW:0]         len;
  logic [NS:0][RW:0]           acc;

  for (genvar k = 0; k < NS; k++) begin : g_cnt
    for (genvar i = 0; i < NS; i++) begin : g_slot
      localparam int L = fms_pkg::slot_rows(ROWS, k + 1, i);
      assign len_tbl[k][i] = (RW+1)'(L);
    end
  end

  assign acc[0] = '0;
  for (genvar i = 0; i < NS; i++) begin : g_chain
    assign len[i]       = len_tbl[code][i];
    assign acc[i+1]     = acc[i] + len[i];
    assign start_row[i] = acc[i][RW-1:0];
    assign last_row[i]  = RW'(acc[i+1] - (RW+1)'(1));
  end

  AST_PART_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    acc[4'(code) + 4'd1] == (RW+1)'(ROWS)); // R2
endmodule

// File: rtl/fms_pick.sv
module fms_pick #(
  parameter int NS  = 8,
  localparam int IW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] req,
  input  logic [IW-1:0] top_idx,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (req[i] && IW'(i) <= top_idx) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

  AST_PICK_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (req[idx] && idx <= top_idx)); // R1
  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((req & ((NS'(1) << idx) - NS'(1))) == '0)); // R4
endmodule

// File: rtl/fms_seq.sv
module fms_seq import fms_pkg::*; #(
  parameter int LED_CYC = 16,
  parameter int RW      = 8,
  localparam int NS     = MAX_SLOTS,
  localparam int IW     = $clog2(NS),
  localparam int CW     = $clog2(LED_CYC + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            cfg_code,
  input  logic                  play_mode,
  input  logic [NS-1:0]         sel_n,
  input  logic                  row_tick,
  input  logic                  row_eom,
  input  logic [NS-1:0][RW-1:0] start_row,
  input  logic [NS-1:0][RW-1:0] last_row,
  input  logic                  pick_hit,
  input  logic [IW-1:0]         pick_idx,
  output logic [2:0]            code_q,
  output logic [NS-1:0]         falls,
  output logic [RW-1:0]         row_addr,
  output logic                  rec_en,
  output logic                  play_en,
  output logic                  eom_set,
  output logic                  led_n
);
  fms_state_e    state;
  logic          mode_q;
  logic [NS-1:0] sel_prev;
  logic [RW-1:0] row;
  logic [IW-1:0] slot;
  logic [CW-1:0] led_cnt;
  logic          own_fall, own_rel, at_last;

  assign falls    = sel_prev & ~sel_n;
  assign own_fall = falls[slot];
  assign own_rel  = sel_n[slot];
  assign at_last  = (row == last_row[slot]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mode_q   <= 1'b0;
      code_q   <= '0;
      sel_prev <= '1;
      row      <= '0;
      slot     <= '0;
      led_cnt  <= '0;
    end else begin
      sel_prev <= sel_n;
      unique case (state)
        ST_IDLE: begin
          if (pick_hit) begin
            slot  <= pick_idx;
            row   <= start_row[pick_idx];
            state <= mode_q ? ST_PLAY : ST_REC;
          end else begin
            code_q <= cfg_code;
            mode_q <= play_mode;
          end
        end
        ST_REC: begin
          if (own_rel || (row_tick && at_last)) begin
            state <= ST_IDLE;
            row   <= '0;
          end else if (row_tick) begin
            row <= row + RW'(1);
          end
        end
        ST_PLAY: begin
          if (own_fall) begin
            state <= ST_IDLE;
            row   <= '0;
          end else if (row_tick) begin
            if (row_eom) begin
              state   <= ST_LED;
              row     <= '0;
              led_cnt <= CW'(LED_CYC - 1);
            end else if (at_last) begin
              state <= ST_IDLE;
              row   <= '0;
            end else begin
              row <= row + RW'(1);
            end
          end
        end
        ST_LED: begin
          if (led_cnt == '0) state <= ST_IDLE;
          else led_cnt <= led_cnt - CW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign row_addr = row;
  assign rec_en   = (state == ST_REC);
  assign play_en  = (state == ST_PLAY);
  assign eom_set  = (state == ST_REC) && (own_rel || (row_tick && at_last));
  assign led_n    = !((state == ST_REC) || (state == ST_LED));

  AST_ROW_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_en || play_en) |-> (row >= start_row[slot] && row <= last_row[slot])); // R7
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_REC || state == ST_PLAY) && state == $past(state))
      |-> (row == $past(row) || row == $past(row) + RW'(1))); // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> ($stable(code_q) && $stable(mode_q))); // R11
  AST_EOM_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    eom_set |=> !rec_en); // R6
  AST_LED_AFTER_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LED && $past(state) != ST_LED) |-> $past(play_en)); // R8
endmodule

// File: rtl/fms_slot_ctrl.sv
module fms_slot_ctrl import fms_pkg::*; #(
  parameter int ROWS    = 256,
  parameter int LED_CYC = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               cfg_code,
  input  logic                     play_mode,
  input  logic [7:0]               sel_n,
  input  logic                     row_tick,
  input  logic                     row_eom,
  output logic [$clog2(ROWS)-1:0]  row_addr,
  output logic                     rec_en,
  output logic                     play_en,
  output logic                     eom_set,
  output logic                     led_n
);
  localparam int RW = $clog2(ROWS);
  localparam int NS = MAX_SLOTS;
  localparam int IW = $clog2(NS);

  logic [NS-1:0][RW-1:0] start_row, last_row;
  logic [2:0]            code_q;
  logic [NS-1:0]         falls;
  logic                  pick_hit;
  logic [IW-1:0]         pick_idx;

  fms_partition #(.ROWS(ROWS)) u_part (
    .clk(clk), .rst_n(rst_n), .code(code_q),
    .start_row(start_row), .last_row(last_row)
  );

  fms_pick #(.NS(NS)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(falls), .top_idx(IW'(code_q)),
    .hit(pick_hit), .idx(pick_idx)
  );

  fms_seq #(.LED_CYC(LED_CYC), .RW(RW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_code(cfg_code), .play_mode(play_mode),
    .sel_n(sel_n), .row_tick(row_tick), .row_eom(row_eom),
    .start_row(start_row), .last_row(last_row),
    .pick_hit(pick_hit), .pick_idx(pick_idx),
    .code_q(code_q), .falls(falls), .row_addr(row_addr),
    .rec_en(rec_en), .play_en(play_en), .eom_set(eom_set), .led_n(led_n)
  );
endmodule

// File: tb/tb_fms_slot_ctrl.sv
`timescale 1ns/1ps
module tb_fms_slot_ctrl;
  localparam int LEDC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_code = '0;
  logic       play_mode = 1'b0;
  logic [7:0] sel_n = '1;
  logic       row_tick = 1'b0;
  logic       a_eom_in;
  int         eom_row = 1000;

  logic [7:0] a_row; logic a_rec, a_play, a_eom, a_led;
  logic [8:0] b_row; logic b_rec, b_play, b_eom, b_led;

  int n_chk = 0;
  int n_err = 0;
  int cyc_cnt = 0;

  always #2 clk = ~clk;

  assign a_eom_in = (int'(a_row) == eom_row);

  fms_slot_ctrl #(.ROWS(256), .LED_CYC(LEDC)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_code(cfg_code), .play_mode(play_mode),
    .sel_n(sel_n), .row_tick(row_tick), .row_eom(a_eom_in),
    .row_addr(a_row), .rec_en(a_rec), .play_en(a_play), .eom_set(a_eom), .led_n(a_led)
  );

  fms_slot_ctrl #(.ROWS(512), .LED_CYC(LEDC)) dut_big (
    .clk(clk), .rst_n(rst_n), .cfg_code(cfg_code), .play_mode(play_mode),
    .sel_n(sel_n), .row_tick(row_tick), .row_eom(1'b0),
    .row_addr(b_row), .rec_en(b_rec), .play_en(b_play), .eom_set(b_eom), .led_n(b_led)
  );

  function automatic int exp_len(int total, int n, int i);
    if (i >= n) return 0;
    if (total == 512 && n == 3) return (i == 0) ? 172 : 170;
    return total / n + ((i < total % n) ? 1 : 0);
  endfunction

  function automatic int exp_start(int total, int n, int i);
    int s;
    s = 0;
    for (int j = 0; j < i; j++) s += exp_len(total, n, j);
    return s;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_cnt);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int n, a_cnt, b_cnt, a_end, b_end, cnt, last;
    bit a_done, b_done;

    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk("R12 rec_en after reset", a_rec, 0);
    chk("R12 play_en after reset", a_play, 0);
    chk("R12 eom_set after reset", a_eom, 0);
    chk("R12 led_n after reset", a_led, 1);
    chk("R12 row_addr after reset", a_row, 0);

    // Sweep every code and every select line in record mode on both array sizes
    for (int code = 0; code < 8; code++) begin
      for (int s = 0; s < 8; s++) begin
        n = code + 1;
        cfg_code = 3'(code); play_mode = 1'b0; sel_n = '1; row_tick = 1'b0;
        repeat (3) cyc();
        sel_n[s] = 1'b0;
        cyc();
        if (s >= n) begin
          chk("R1 disabled line ignored (256)", a_rec, 0);
          chk("R1 disabled line ignored (512)", b_rec, 0);
        end else begin
          chk("R5 rec_en set", a_rec, 1);
          chk("R5 led_n low while recording", a_led, 0);
          chk("R2 first row (256)", a_row, exp_start(256, n, s));
          chk("R3 first row (512)", b_row, exp_start(512, n, s));
          row_tick = 1'b1;
          a_cnt = 0; b_cnt = 0; a_end = -1; b_end = -1; a_done = 0; b_done = 0;
          for (int g = 0; g < 600 && !(a_done && b_done); g++) begin
            #1;
            if (!a_done && a_rec) begin
              a_cnt++;
              if (a_eom) begin a_done = 1; a_end = a_row; end
            end
            if (!b_done && b_rec) begin
              b_cnt++;
              if (b_eom) begin b_done = 1; b_end = b_row; end
            end
            cyc();
          end
          chk("R2 rows recorded (256)", a_cnt, exp_len(256, n, s));
          chk("R7 end-flag row (256)", a_end, exp_start(256, n, s) + exp_len(256, n, s) - 1);
          chk("R3 rows recorded (512)", b_cnt, exp_len(512, n, s));
          chk("R7 end-flag row (512)", b_end, exp_start(512, n, s) + exp_len(512, n, s) - 1);
          row_tick = 1'b0;
        end
        sel_n = '1;
        cyc(); cyc();
        chk("R7 idle after slot end", a_rec, 0);
      end
    end

    // R4: two enabled lines fall together
    cfg_code = 3'd7; play_mode = 1'b0;
    repeat (3) cyc();
    sel_n = ~8'b0010_0100;
    cyc();
    chk("R4 lowest of slots 2 and 5 wins", a_row, 64);
    sel_n = '1; cyc(); cyc();
    cfg_code = 3'd1;
    repeat (3) cyc();
    sel_n = ~8'b0010_0010;
    cyc();
    chk("R4 disabled slot 5 loses to slot 1", a_row, 128);
    sel_n = '1; cyc(); cyc();

    // R6: release mid-slot
    cfg_code = 3'd0;
    repeat (3) cyc();
    sel_n[0] = 1'b0;
    cyc();
    row_tick = 1'b1;
    cyc(); cyc(); cyc();
    row_tick = 1'b0; sel_n[0] = 1'b1;
    #1;
    chk("R6 eom_set on release", a_eom, 1);
    chk("R6 end-flag row on release", a_row, 3);
    cyc();
    chk("R6 rec_en cleared", a_rec, 0);
    chk("R6 led_n released", a_led, 1);

    // R8: playback to a stored end flag
    cfg_code = 3'd3; play_mode = 1'b1;
    repeat (3) cyc();
    eom_row = 130;
    sel_n[2] = 1'b0;
    cyc();
    sel_n[2] = 1'b1;
    chk("R8 play_en set", a_play, 1);
    chk("R8 play first row", a_row, 128);
    chk("R8 led_n high while playing", a_led, 1);
    row_tick = 1'b1;
    cyc(); cyc();
    chk("R8 reached flagged row", a_row, 130);
    cyc();
    row_tick = 1'b0;
    chk("R8 play_en cleared at end flag", a_play, 0);
    cnt = 0;
    for (int g = 0; g < 20 && a_led == 1'b0; g++) begin
      cnt++;
      cyc();
    end
    chk("R8 LED pulse length", cnt, LEDC);

    // R9 and R11: play to slot end, config and mode changed mid-run
    eom_row = 1000;
    repeat (2) cyc();
    sel_n[2] = 1'b0;
    cyc();
    sel_n[2] = 1'b1;
    cfg_code = 3'd0; play_mode = 1'b0;
    row_tick = 1'b1;
    cnt = 0; last = -1;
    for (int g = 0; g < 400 && a_play; g++) begin
      last = a_row;
      cnt++;
      cyc();
    end
    row_tick = 1'b0;
    chk("R9 R11 last row played", last, 191);
    chk("R11 rows played with frozen config", cnt, 64);
    chk("R9 no LED pulse at slot end", a_led, 1);
    chk("R11 no recording started", a_rec, 0);

    // R10: other line ignored, own line stops
    cfg_code = 3'd3; play_mode = 1'b1;
    repeat (3) cyc();
    sel_n[1] = 1'b0;
    cyc();
    sel_n[1] = 1'b1;
    chk("R10 play slot 1 first row", a_row, 64);
    sel_n[3] = 1'b0;
    cyc();
    chk("R10 other line ignored, still playing", a_play, 1);
    chk("R10 other line ignored, row kept", a_row, 64);
    sel_n[3] = 1'b1;
    cyc();
    sel_n[1] = 1'b0;
    cyc();
    chk("R10 own line stops playback", a_play, 0);
    chk("R10 no LED pulse on stop", a_led, 1);
    sel_n = '1;
    cyc();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule